// File: doc/BRIEF.md
# Receive Ring Descriptor Consumer

This block drains completed frames from a receive ring that sits in a 16-bit-wide on-chip buffer memory. Each frame in the ring begins with a four-word header, followed by the payload words. When `kick` is pulsed, the block starts at its current head pointer and walks frame to frame. It follows the next-frame pointer stored in each header rather than stepping through the memory by index. The walk stops at the first header whose first word is not the completion marker.

A good frame has its payload streamed out on a ready/valid port, one 16-bit word per beat, with a byte-enable and a last flag. A bad frame is skipped without producing any beats. Both kinds are counted, and both advance the head. When the walk ends, the block computes a fresh stop limit two bytes behind the head, writes it back to the receive side, and raises a one-cycle completion pulse.

The state machine has eight states:
- S_IDLE waits for a kick.
- S_HDR_RD issues a header read.
- S_HDR_CHK consumes the returned header word.
- S_PAY_RD issues a payload read.
- S_PAY_LAT latches the returned payload word.
- S_PAY_OUT offers the latched word downstream.
- S_STOP writes the stop limit.
- S_DONE pulses completion.

Its transitions are:
- idle-to-read on a kick.
- read-to-check.
- check-to-read for the next header word, or for a bad frame, or for a good frame with zero length.
- check-to-payload for a good frame with a non-zero length.
- check-to-stop on a marker mismatch.
- payload-read to latch to offer.
- offer-to-payload-read on an accepted non-final beat.
- offer-to-header-read on an accepted final beat.
- stop-to-done.
- done-to-idle.

Top module: `rx_ring_consumer`

## Requirements
- R1: After reset, `ring_head` equals LOWER. `stop_limit` equals UPPER with its low eight bits forced to 0xFE. Both counters are zero, and `m_valid`, `mem_rd_en` and `pass_done` are low.
- R2: The walk continues while the word at a header's offset 0 equals DONE_MARK. At the first header whose offset-0 word differs, the walk ends and no further word of that header is read.
- R3: The header word offsets are fixed: +0 is the marker, +2 is the status, +4 is the next-frame byte pointer, and +6 is the payload byte count. The payload starts at +8.
- R4: After each frame, good or bad, `ring_head` takes the next-frame pointer from that frame's header. The head changes at no other time.
- R5: A frame whose status word has bit OK_BIT set is good: its payload is streamed and `good_count` increments by one. A frame with that bit clear produces no beats and increments `bad_count` by one.
- R6: A good frame of N bytes produces ceil(N/2) beats. Byte 2k of the payload is in `m_data[7:0]` of beat k, and byte 2k+1 is in `m_data[15:8]`. `m_keep` is 2'b11 on every beat except the final beat of an odd N, where it is 2'b01. `m_last` is set only on the final beat. When N is 0, no beat is produced and the frame still counts as good.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_keep` and `m_last` hold their values.
- R8: Every read address is even and lies within LOWER..UPPER. The word after UPPER is LOWER, for both header and payload words.
- R9: At the end of each walk, `stop_limit` is loaded with UPPER if the head is below LOWER+2, and with head-2 otherwise.
- R10: `pass_done` is high for exactly one cycle. That cycle is the one after `stop_limit` is written.
- R11: A kick that arrives while a walk is in progress is ignored and does not start a second walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Start a walk when idle |
| mem_rd_en | output | 1 | Buffer memory read strobe |
| mem_addr | output | AW | Byte address of the read word (bit 0 always 0) |
| mem_rd_data | input | 16 | Read data, valid the cycle after the strobe |
| m_valid | output | 1 | Payload beat valid |
| m_ready | input | 1 | Downstream accepts beat |
| m_data | output | 16 | Payload word, earlier byte in the low half |
| m_keep | output | 2 | Valid bytes of the beat |
| m_last | output | 1 | Final beat of a frame |
| ring_head | output | AW | Current head byte pointer |
| stop_limit | output | AW | Stop limit written back to the receive side |
| good_count | output | CW | Good frames delivered (wraps) |
| bad_count | output | CW | Bad frames skipped (wraps) |
| pass_done | output | 1 | One-cycle pulse at walk completion |

## Verification
The bench fills a small ring with batches of ten frames. Within a batch, payload lengths sweep 0 to 11 bytes in a rotating order, and every fourth frame has its OK bit cleared while its other status bits are set. This separates even lengths from odd ones, zero-length frames from streamed frames, and good frames from bad frames.

Successive batches run with the sink always ready, ready on alternate cycles, and ready one cycle in three. This tells a correct beat hold apart from dropped or duplicated words. The batches also march the layout across UPPER, so headers and payloads are exercised when they wrap.

Walks over an empty ring and a frame whose pointer jumps back to LOWER reach the stop-limit special case. Terminators equal to zero and one bit away from the marker show that near-miss markers end the walk. A second kick issued mid-walk shows that it starts nothing.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR_RD,
        S_HDR_CHK,
        S_PAY_RD,
        S_PAY_LAT,
        S_PAY_OUT,
        S_STOP,
        S_DONE
    } rxr_state_e;

    typedef enum logic [1:0] {
        W_MARK,
        W_STAT,
        W_NEXT,
        W_CNT
    } rxr_hword_e;

    localparam int unsigned WORD_W = 16;

endpackage

// File: rtl/rxr_ring_step.sv
module rxr_ring_step #(
    parameter int unsigned     AW    = 16,
    parameter logic [AW-1:0]   LOWER = '0,
    parameter logic [AW-1:0]   UPPER = '1
) (
    input  logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    localparam logic [AW-1:0] STEP = AW'(2);

    // the last word of the ring is followed by the first one
    always_comb begin
        if (cur_addr == UPPER)
            nxt_addr = LOWER;
        else
            nxt_addr = cur_addr + STEP;
    end

endmodule

// File: rtl/rxr_stop_rule.sv
module rxr_stop_rule #(
    parameter int unsigned     AW    = 16,
    parameter logic [AW-1:0]   LOWER = '0,
    parameter logic [AW-1:0]   UPPER = '1
) (
    input  logic [AW-1:0] head,
    output logic [AW-1:0] stop_val
);
    localparam logic [AW:0] EDGE = {1'b0, LOWER} + (AW+1)'(2);

    // R9: stop two bytes behind the head, or at the ring top when the
    // head sits on the bottom boundary
    always_comb begin
        if ({1'b0, head} < EDGE)
            stop_val = UPPER;
        else
            stop_val = head - AW'(2);
    end

endmodule

// File: rtl/rxr_tally.sv
module rxr_tally #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_good,
    input  logic          inc_bad,
    output logic [CW-1:0] good_cnt,
    output logic [CW-1:0] bad_cnt
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_cnt <= '0;
            bad_cnt  <= '0;
        end else begin
            if (inc_good)
                good_cnt <= good_cnt + ONE;
            if (inc_bad)
                bad_cnt <= bad_cnt + ONE;
        end
    end

    // R5: one frame closes at a time, either good or bad
    a_r5_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_good && inc_bad));

endmodule

// File: rtl/rxr_beat_reg.sv
module rxr_beat_reg #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] word_in,
    input  logic [15:0]   rem_bytes,
    output logic [DW-1:0] word_q,
    output logic [1:0]    keep_q,
    output logic          last_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            keep_q <= 2'b00;
            last_q <= 1'b0;
        end else if (load) begin
            word_q <= word_in;
            keep_q <= (rem_bytes == 16'd1) ? 2'b01 : 2'b11;
            last_q <= (rem_bytes <= 16'd2);
        end
    end

endmodule

// File: rtl/rx_ring_consumer.sv
module rx_ring_consumer
    import rxr_pkg::*;
#(
    parameter int unsigned     AW        = 16,
    parameter int unsigned     CW        = 16,
    parameter logic [AW-1:0]   LOWER     = '0,
    parameter logic [AW-1:0]   UPPER     = AW'(16'h5FFE),
    parameter logic [15:0]     DONE_MARK = 16'h00A8,
    parameter int unsigned     OK_BIT    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [15:0]   mem_rd_data,
    output logic          m_valid,
    input  logic          m_ready,
    output logic [15:0]   m_data,
    output logic [1:0]    m_keep,
    output logic          m_last,
    output logic [AW-1:0] ring_head,
    output logic [AW-1:0] stop_limit,
    output logic [CW-1:0] good_count,
    output logic [CW-1:0] bad_count,
    output logic          pass_done
);
    localparam logic [AW-1:0] STOP_INIT = UPPER | AW'(8'hFE);

    rxr_state_e    state, state_d;
    rxr_hword_e    hidx;
    logic [AW-1:0] cursor;
    logic [AW-1:0] cursor_nx;
    logic [AW-1:0] head_q;
    logic [AW-1:0] next_q;
    logic [AW-1:0] stop_q;
    logic [AW-1:0] stop_cand;
    logic [15:0]   rem_q;
    logic          ok_q;
    logic          mark_hit;
    logic          inc_good;
    logic          inc_bad;
    logic          beat_load;
    logic          beat_last;

    rxr_ring_step #(.AW(AW), .LOWER(LOWER), .UPPER(UPPER)) u_step (
        .cur_addr (cursor),
        .nxt_addr (cursor_nx)
    );

    rxr_stop_rule #(.AW(AW), .LOWER(LOWER), .UPPER(UPPER)) u_stop (
        .head     (head_q),
        .stop_val (stop_cand)
    );

    rxr_tally #(.CW(CW)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_good (inc_good),
        .inc_bad  (inc_bad),
        .good_cnt (good_count),
        .bad_cnt  (bad_count)
    );

    rxr_beat_reg #(.DW(WORD_W)) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (beat_load),
        .word_in   (mem_rd_data),
        .rem_bytes (rem_q),
        .word_q    (m_data),
        .keep_q    (m_keep),
        .last_q    (beat_last)
    );

    assign mark_hit  = (mem_rd_data == DONE_MARK);
    assign beat_load = (state == S_PAY_LAT);

    // frame verdicts
    always_comb begin
        inc_bad  = (state == S_HDR_CHK) && (hidx == W_CNT) && !ok_q;
        inc_good = ((state == S_HDR_CHK) && (hidx == W_CNT) && ok_q &&
                    (mem_rd_data == 16'd0)) ||
                   ((state == S_PAY_OUT) && m_ready && beat_last);
    end

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:    if (kick) state_d = S_HDR_RD;
            S_HDR_RD:  state_d = S_HDR_CHK;
            S_HDR_CHK: begin
                unique case (hidx)
                    W_MARK: state_d = mark_hit ? S_HDR_RD : S_STOP;
                    W_STAT: state_d = S_HDR_RD;
                    W_NEXT: state_d = S_HDR_RD;
                    W_CNT:  state_d = (ok_q && mem_rd_data != 16'd0) ?
                                      S_PAY_RD : S_HDR_RD;
                endcase
            end
            S_PAY_RD:  state_d = S_PAY_LAT;
            S_PAY_LAT: state_d = S_PAY_OUT;
            S_PAY_OUT: if (m_ready) state_d = beat_last ? S_HDR_RD : S_PAY_RD;
            S_STOP:    state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hidx   <= W_MARK;
            cursor <= LOWER;
            head_q <= LOWER;
            next_q <= LOWER;
            stop_q <= STOP_INIT;
            rem_q  <= '0;
            ok_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (kick) begin
                        cursor <= head_q;
                        hidx   <= W_MARK;
                    end
                end
                S_HDR_CHK: begin
                    unique case (hidx)
                        W_MARK: begin
                            if (mark_hit) begin
                                cursor <= cursor_nx;
                                hidx   <= W_STAT;
                            end
                        end
                        W_STAT: begin
                            ok_q   <= mem_rd_data[OK_BIT];
                            cursor <= cursor_nx;
                            hidx   <= W_NEXT;
                        end
                        W_NEXT: begin
                            next_q <= mem_rd_data[AW-1:0];
                            cursor <= cursor_nx;
                            hidx   <= W_CNT;
                        end
                        W_CNT: begin
                            rem_q <= mem_rd_data;
                            hidx  <= W_MARK;
                            if (!ok_q || mem_rd_data == 16'd0) begin
                                head_q <= next_q;
                                cursor <= next_q;
                            end else begin
                                cursor <= cursor_nx;
                            end
                        end
                    endcase
                end
                S_PAY_OUT: begin
                    if (m_ready) begin
                        if (beat_last) begin
                            head_q <= next_q;
                            cursor <= next_q;
                        end else begin
                            rem_q  <= rem_q - 16'd2;
                            cursor <= cursor_nx;
                        end
                    end
                end
                S_STOP: stop_q <= stop_cand;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd_en  = (state == S_HDR_RD) || (state == S_PAY_RD);
        mem_addr   = cursor;
        m_valid    = (state == S_PAY_OUT);
        m_last     = beat_last;
        pass_done  = (state == S_DONE);
        ring_head  = head_q;
        stop_limit = stop_q;
    end

    // R2: a header whose first word is not the marker ends the walk
    a_r2_stop_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR_CHK && hidx == W_MARK && mem_rd_data != DONE_MARK)
        |=> (state == S_STOP && !mem_rd_en));

    // R4: the head only moves when a frame closes
    a_r4_head_moves_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ring_head) |-> ($past(inc_good) || $past(inc_bad)));

    // R6: byte enables are full except on a final odd beat
    a_r6_keep_shape: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_keep == 2'b11 || (m_keep == 2'b01 && m_last)));

    // R7: an offered beat is held until taken
    a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) &&
                                   $stable(m_keep) && $stable(m_last)));

    // R8: reads stay word aligned inside the ring
    a_r8_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (!mem_addr[0] && mem_addr >= LOWER && mem_addr <= UPPER));

    // R9: stop limit seen at completion follows the head rule
    a_r9_stop_rule: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (({1'b0, ring_head} < ({1'b0, LOWER} + (AW+1)'(2))) ?
                       (stop_limit == UPPER) : (stop_limit == ring_head - AW'(2))));

    // R10: completion is a single-cycle pulse with no beat pending
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    a_r10_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (!m_valid && !mem_rd_en));

endmodule

// File: tb/tb_rx_ring_consumer.sv
module tb_rx_ring_consumer;

    localparam int unsigned   AW    = 12;
    localparam int unsigned   CW    = 16;
    localparam logic [AW-1:0] LOWER = 12'h100;
    localparam logic [AW-1:0] UPPER = 12'h2F0;
    localparam logic [15:0]   MARK  = 16'hC3A5;
    localparam int unsigned   OKB   = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kick = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rd_data = '0;
    logic          m_valid;
    logic          m_ready = 1'b0;
    logic [15:0]   m_data;
    logic [1:0]    m_keep;
    logic          m_last;
    logic [AW-1:0] ring_head;
    logic [AW-1:0] stop_limit;
    logic [CW-1:0] good_count;
    logic [CW-1:0] bad_count;
    logic          pass_done;

    rx_ring_consumer #(
        .AW(AW), .CW(CW), .LOWER(LOWER), .UPPER(UPPER),
        .DONE_MARK(MARK), .OK_BIT(OKB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .kick(kick),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_keep(m_keep), .m_last(m_last),
        .ring_head(ring_head), .stop_limit(stop_limit),
        .good_count(good_count), .bad_count(bad_count),
        .pass_done(pass_done)
    );

    always #5 clk = ~clk;

    logic [15:0] mem [0:(1<<(AW-1))-1];
    always @(posedge clk) begin
        if (mem_rd_en)
            mem_rd_data <= mem[mem_addr[AW-1:1]];
    end

    int nchk = 0;
    int nfail = 0;
    int pass_cnt = 0;
    int cyc = 0;
    int rmode = 0;
    int exp_good = 0;
    int exp_bad = 0;
    logic [AW-1:0] tail;
    logic [18:0] expq [$];
    logic        hold_prev = 1'b0;
    logic [18:0] hold_val;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
        return (a == UPPER) ? LOWER : a + AW'(2);
    endfunction

    function automatic logic [AW-1:0] exp_stop(input logic [AW-1:0] h);
        return (h < LOWER + AW'(2)) ? UPPER : h - AW'(2);
    endfunction

    // sink: checks hold, drives ready, scores beats
    always @(negedge clk) begin
        cyc++;
        if (rst_n && hold_prev) begin
            chk("R7 valid held", {31'd0, m_valid}, 32'd1);
            chk("R7 beat held", {13'd0, m_keep, m_last, m_data}, {13'd0, hold_val});
        end
        case (rmode)
            0:       m_ready = 1'b1;
            1:       m_ready = (cyc % 2) == 0;
            default: m_ready = (cyc % 3) == 0;
        endcase
        if (rst_n && m_valid && m_ready) begin
            if (expq.size() == 0) begin
                chk("R5 unexpected beat", {13'd0, m_keep, m_last, m_data}, 32'h7FFFF);
            end else begin
                chk("R6 beat", {13'd0, m_keep, m_last, m_data}, {13'd0, expq.pop_front()});
            end
        end
        hold_prev = rst_n && m_valid && !m_ready;
        hold_val  = {m_keep, m_last, m_data};
        if (rst_n && pass_done)
            pass_cnt++;
    end

    // one frame at tail; returns with tail past it
    task automatic put_frame(input bit ok, input int cnt, input int seed);
        logic [AW-1:0] a;
        logic [AW-1:0] nslot;
        logic [7:0]    b0, b1;
        int nw;
        a = tail;
        mem[a[AW-1:1]] = MARK;
        a = step(a);
        mem[a[AW-1:1]] = ok ? (16'h00C1 | (16'h1 << OKB)) : (16'hFFFF & ~(16'h1 << OKB));
        a = step(a);
        nslot = a;
        a = step(a);
        mem[a[AW-1:1]] = 16'(cnt);
        a = step(a);
        nw = (cnt + 1) / 2;
        for (int w = 0; w < nw; w++) begin
            b0 = 8'((seed + 2*w) * 7 + 3);
            b1 = (2*w + 1 < cnt) ? 8'((seed + 2*w + 1) * 7 + 3) : 8'hEE;
            mem[a[AW-1:1]] = {b1, b0};
            if (ok)
                expq.push_back({(2*w + 1 < cnt) ? 2'b11 : 2'b01, (w == nw - 1), b1, b0});
            a = step(a);
        end
        mem[nslot[AW-1:1]] = 16'(a);
        tail = a;
        if (ok) exp_good++; else exp_bad++;
    endtask

    task automatic put_term(input logic [15:0] v);
        mem[tail[AW-1:1]] = v;
        mem[step(tail) >> 1] = 16'hFFFF;
    endtask

    task automatic run_pass(input bit second_kick, input string tag);
        int start;
        int waited;
        start = pass_cnt;
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        if (second_kick) begin
            repeat (5) @(negedge clk);
            kick = 1'b1;
            @(negedge clk); kick = 1'b0;
        end
        waited = 0;
        while (pass_cnt == start && waited < 4000) begin
            @(negedge clk); #1;
            waited++;
        end
        chk({"R10 pass completed ", tag}, pass_cnt, start + 1);
        chk({"R10 pulse high ", tag}, {31'd0, pass_done}, 32'd1);
        chk({"R4 head ", tag}, {20'd0, ring_head}, {20'd0, tail});
        chk({"R9 stop ", tag}, {20'd0, stop_limit}, {20'd0, exp_stop(tail)});
        chk({"R5 good count ", tag}, {16'd0, good_count}, 32'(exp_good));
        chk({"R5 bad count ", tag}, {16'd0, bad_count}, 32'(exp_bad));
        repeat (20) @(negedge clk);
        #1;
        chk({"R11 single pass ", tag}, pass_cnt, start + 1);
        chk({"R10 pulse ended ", tag}, {31'd0, pass_done}, 32'd0);
        chk({"R6 all beats seen ", tag}, expq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << (AW-1)); i++) mem[i] = 16'h0000;
        tail = LOWER;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 head", {20'd0, ring_head}, {20'd0, LOWER});
        chk("R1 stop", {20'd0, stop_limit}, {20'd0, UPPER | 12'h0FE});
        chk("R1 good", {16'd0, good_count}, 0);
        chk("R1 bad", {16'd0, bad_count}, 0);
        chk("R1 idle outputs", {29'd0, m_valid, mem_rd_en, pass_done}, 0);

        // R2/R9: empty ring at the lower boundary
        run_pass(1'b0, "empty");

        // R3/R5/R6/R8: batches sweep lengths, verdicts, sink patterns and wrap
        for (int b = 0; b < 9; b++) begin
            rmode = b % 3;
            for (int f = 0; f < 10; f++)
                put_frame(((f + b) % 4) != 3, (f + b) % 12, b * 16 + f);
            put_term((b % 2) ? (MARK ^ 16'h0001) : 16'h0000);
            run_pass(b == 2, $sformatf("batch%0d", b));
        end

        // R4/R9: a bad frame pointing back to LOWER
        rmode = 0;
        mem[tail[AW-1:1]] = MARK;
        mem[step(tail) >> 1] = 16'h0000;
        mem[step(step(tail)) >> 1] = 16'(LOWER);
        mem[step(step(step(tail))) >> 1] = 16'd4;
        exp_bad++;
        tail = LOWER;
        put_term(MARK ^ 16'h8000);
        run_pass(1'b0, "jump");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule